// File: doc/BRIEF.md
# Pixel Output Formatter with Data-Valid Strobe

This block sits at the end of an imaging pixel pipeline. It takes finished 12-bit pixels, each tagged with its source colour channel, an out-of-range flag and a per-pixel valid bit from the coefficient stream. It presents them on a shared output bus with a colour code and an active-low data-valid strobe. Each pixel occupies two clock cycles, called the first and second half. The colour code marks the half on its low bit, which lets an external memory address two coefficient bytes per pixel.

The strobe can be limited to chosen colours. The choice comes either from a per-channel enable mask or from the valid bit that travels with each pixel. The bus can be frozen so that it changes only on pixels that raise the strobe. The pixel can be cut to 10 significant bits. It can also be split into two bytes on the upper bus bits, with the out-of-range flag in the last bit of the second byte. A single active-low enable puts every output into high impedance.

Pixels arrive on a valid/ready stream. `in_ready` is low only during the first half of a pixel in progress, so a new pixel can be accepted on the clock that ends the second half. A producer that keeps `in_valid` high therefore gets one pixel every two cycles. Holding `in_valid` low leaves the block idle and does not lose a pixel. All configuration inputs are expected to be steady while a pixel is in flight.

Top module: `pix_out_fmt`

## Requirements
- R1: After reset, with `oe_n` low, `op_o` is 0, `orng_o` is 0, `cc_o` is 000, `dv_n_o` is 1 and `in_ready` is 1.
- R2: A pixel is accepted on a clock edge where `in_valid` and `in_ready` are both high. It is shown from the next cycle for exactly two cycles. `in_ready` is low during the first of those cycles and high during the second.
- R3: `cc_o[2:1]` carries the channel code of the pixel on show: red 00, green 01, blue 10. `cc_o[0]` is 0 in the first half and 1 in the second half. While idle, `cc_o[0]` is 0 and `cc_o[2:1]` keep their last value.
- R4: When `cfg_mono` is 1 at acceptance, `cc_o[2:1]` show `cfg_mono_chan` instead of the pixel's own channel code.
- R5: `dv_n_o` is low for both halves of a pixel whose strobe is selected. It is high for unselected pixels and whenever the block is idle.
- R6: With `cfg_dv_from_stream` at 0, a pixel is selected when `cfg_dv_mask[c]` is 1. Here c is the channel code: bit 0 is red, bit 1 green and bit 2 blue. Channel code 11 is never selected.
- R7: With `cfg_dv_from_stream` at 1, a pixel is selected when its `in_cdv` bit is 1, whatever the mask.
- R8: With `cfg_hold` at 0, every accepted pixel replaces the shown word and flag. With `cfg_hold` at 1, only selected pixels replace them, and unselected pixels leave `op_o` and `orng_o` unchanged.
- R9: With `cfg_wide` at 1, the full 12-bit pixel is shown. With `cfg_wide` at 0, bits 11..2 are shown and bits 1..0 read 0.
- R10: With `cfg_byte_split` at 1, `op_o[11:4]` carries word bits 11..4 in the first half. In the second half it carries word bits 3..0, then 000, then the out-of-range flag in `op_o[4]`. `op_o[3:0]` read 0. When idle, the first-half byte is shown.
- R11: With `oe_n` at 1, `op_o`, `orng_o`, `cc_o` and `dv_n_o` are all high impedance. Internal state advances as usual.
- R12: `orng_o` carries the out-of-range flag of the shown word, under the same hold rule as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wide | input | 1 | 1: 12-bit word, 0: 10-bit word |
| cfg_byte_split | input | 1 | Split each pixel into two bytes on the upper bus |
| cfg_hold | input | 1 | Update bus only on strobed pixels |
| cfg_dv_from_stream | input | 1 | Strobe source: 1 stream bit, 0 channel mask |
| cfg_dv_mask | input | 3 | Per-channel strobe enables (bit 0 red) |
| cfg_mono | input | 1 | Report fixed channel code |
| cfg_mono_chan | input | 2 | Channel code reported in mono |
| oe_n | input | 1 | Active-low output enable |
| in_valid | input | 1 | Pixel stream valid |
| in_ready | output | 1 | Pixel stream ready |
| in_data | input | 12 | Pixel value |
| in_orng | input | 1 | Pixel out-of-range flag |
| in_chan | input | 2 | Pixel channel code |
| in_cdv | input | 1 | Per-pixel strobe bit from coefficient stream |
| op_o | output | 12 | Output bus |
| orng_o | output | 1 | Out-of-range flag of shown word |
| cc_o | output | 3 | Colour code and half marker |
| dv_n_o | output | 1 | Active-low data valid |

## Verification
The hardest situation to reach is a frozen bus under the hold option. To expose it, an unselected pixel must follow a selected one and carry different data, flag and format settings. The bench reaches it by sweeping every combination of strobe source, channel mask, stream bit, channel, hold, width and byte split over a pixel sequence whose values change on every step. The bench keeps its own copy of the last shown word. After each pixel, that copy is compared with the bus in both halves.

// File: rtl/pof_pkg.sv
package pof_pkg;
  localparam int CODE_W = 2;
  localparam logic [CODE_W-1:0] CODE_RED   = 2'b00;
  localparam logic [CODE_W-1:0] CODE_GREEN = 2'b01;
  localparam logic [CODE_W-1:0] CODE_BLUE  = 2'b10;
endpackage

// File: rtl/pof_pace.sv
module pof_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic take,
  output logic busy,
  output logic half
);
  logic busy_q, half_q;

  assign in_ready = !busy_q || half_q;
  assign take     = in_valid && in_ready;
  assign busy     = busy_q;
  assign half     = half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end else if (take) begin
      busy_q <= 1'b1;
      half_q <= 1'b0;
    end else if (busy_q && !half_q) begin
      half_q <= 1'b1;
    end else begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pof_dv_pick.sv
module pof_dv_pick #(
  parameter int NCHAN = 3
) (
  input  logic                    from_stream,
  input  logic [NCHAN-1:0]        mask,
  input  logic [pof_pkg::CODE_W-1:0] chan,
  input  logic                    cdv,
  output logic                    sel
);
  logic [NCHAN-1:0] hit;

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    assign hit[c] = mask[c] && (chan == pof_pkg::CODE_W'(c));
  end

  assign sel = from_stream ? cdv : |hit;
endmodule

// File: rtl/pof_word_shape.sv
module pof_word_shape #(
  parameter int PIX_W    = 12,
  parameter int NARROW_W = 10
) (
  input  logic             wide,
  input  logic [PIX_W-1:0] din,
  output logic [PIX_W-1:0] dout
);
  localparam int CUT_W = PIX_W - NARROW_W;

  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    if (b < CUT_W) begin : g_cut
      assign dout[b] = wide & din[b];
    end else begin : g_keep
      assign dout[b] = din[b];
    end
  end
endmodule

// File: rtl/pof_lane_mux.sv
module pof_lane_mux #(
  parameter int PIX_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             byte_split,
  input  logic             half,
  input  logic [PIX_W-1:0] word,
  input  logic             orng,
  output logic [PIX_W-1:0] bus
);
  localparam int LOW_W = PIX_W - BYTE_W;
  localparam int PAD_W = BYTE_W - LOW_W - 1;

  logic [BYTE_W-1:0] byte_a, byte_b, lane;

  assign byte_a = word[PIX_W-1:LOW_W];
  assign byte_b = {word[LOW_W-1:0], {PAD_W{1'b0}}, orng};
  assign lane   = half ? byte_b : byte_a;

  always_comb begin
    if (byte_split) bus = {lane, {LOW_W{1'b0}}};
    else            bus = word;
  end
endmodule

// File: rtl/pix_out_fmt.sv
module pix_out_fmt #(
  parameter int PIX_W    = 12,
  parameter int NARROW_W = 10,
  parameter int BYTE_W   = 8,
  parameter int NCHAN    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wide,
  input  logic             cfg_byte_split,
  input  logic             cfg_hold,
  input  logic             cfg_dv_from_stream,
  input  logic [NCHAN-1:0] cfg_dv_mask,
  input  logic             cfg_mono,
  input  logic [1:0]       cfg_mono_chan,
  input  logic             oe_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_orng,
  input  logic [1:0]       in_chan,
  input  logic             in_cdv,
  output logic [PIX_W-1:0] op_o,
  output logic             orng_o,
  output logic [2:0]       cc_o,
  output logic             dv_n_o
);
  import pof_pkg::*;

  logic take, busy, half, sel;
  logic [PIX_W-1:0] shaped, held_word, bus;
  logic held_orng, dv_q;
  logic [CODE_W-1:0] code_q;

  pof_pace u_pace (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .take(take), .busy(busy), .half(half)
  );

  pof_dv_pick #(.NCHAN(NCHAN)) u_pick (
    .from_stream(cfg_dv_from_stream), .mask(cfg_dv_mask),
    .chan(in_chan), .cdv(in_cdv), .sel(sel)
  );

  pof_word_shape #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) u_shape (
    .wide(cfg_wide), .din(in_data), .dout(shaped)
  );

  // Hold registers: word and flag change only when the hold rule allows.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_word <= '0;
      held_orng <= 1'b0;
      code_q    <= CODE_RED;
      dv_q      <= 1'b0;
    end else if (take) begin
      code_q <= cfg_mono ? cfg_mono_chan : in_chan;
      dv_q   <= sel;
      if (!cfg_hold || sel) begin
        held_word <= shaped;
        held_orng <= in_orng;
      end
    end
  end

  pof_lane_mux #(.PIX_W(PIX_W), .BYTE_W(BYTE_W)) u_lane (
    .byte_split(cfg_byte_split), .half(half),
    .word(held_word), .orng(held_orng), .bus(bus)
  );

  assign op_o   = oe_n ? {PIX_W{1'bz}} : bus;
  assign orng_o = oe_n ? 1'bz : held_orng;
  assign cc_o   = oe_n ? 3'bzzz : {code_q, half};
  assign dv_n_o = oe_n ? 1'bz : !(busy && dv_q);
endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oe_n,
  input logic             cfg_mono,
  input logic [1:0]       cfg_mono_chan,
  input logic             cfg_byte_split,
  input logic             in_valid,
  input logic             in_ready,
  input logic [PIX_W-1:0] op_o,
  input logic [2:0]       cc_o,
  input logic             dv_n_o
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_first_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  p_second_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  p_half_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !oe_n) |-> (cc_o[0] == 1'b0));

  p_mono_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg_mono) |=> (oe_n || cc_o[2:1] == $past(cfg_mono_chan)));

  p_idle_dv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && in_ready && cc_o[0] == 1'b0 && !$past(acc)) |-> dv_n_o);

  p_dv_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !in_ready) |=> (oe_n || dv_n_o == $past(dv_n_o)));

  p_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && cfg_byte_split) |-> (op_o[3:0] == 4'h0));
endmodule

bind pix_out_fmt pof_checker #(.PIX_W(PIX_W)) u_pof_checker (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .cfg_mono(cfg_mono),
  .cfg_mono_chan(cfg_mono_chan), .cfg_byte_split(cfg_byte_split),
  .in_valid(in_valid), .in_ready(in_ready), .op_o(op_o),
  .cc_o(cc_o), .dv_n_o(dv_n_o)
);

// File: tb/pix_out_fmt_bench.sv
module pix_out_fmt_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wide = 1'b1, cfg_byte_split = 1'b0, cfg_hold = 1'b0;
  logic cfg_dv_from_stream = 1'b0, cfg_mono = 1'b0, oe_n = 1'b0;
  logic [2:0] cfg_dv_mask = 3'b001;
  logic [1:0] cfg_mono_chan = 2'b00;
  logic in_valid = 1'b0, in_orng = 1'b0, in_cdv = 1'b0;
  logic [11:0] in_data = '0;
  logic [1:0] in_chan = '0;
  logic in_ready, orng_o, dv_n_o;
  logic [11:0] op_o;
  logic [2:0] cc_o;

  int checks = 0, errors = 0, idx = 0;
  logic finished = 1'b0;
  logic [11:0] m_word = '0;
  logic m_orng = 1'b0;
  logic [1:0] m_code = '0;

  always #(CLK_NS/2) clk = ~clk;

  pix_out_fmt u_pix_out_fmt (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_byte_split(cfg_byte_split),
    .cfg_hold(cfg_hold), .cfg_dv_from_stream(cfg_dv_from_stream),
    .cfg_dv_mask(cfg_dv_mask), .cfg_mono(cfg_mono), .cfg_mono_chan(cfg_mono_chan),
    .oe_n(oe_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_orng(in_orng), .in_chan(in_chan), .in_cdv(in_cdv), .op_o(op_o),
    .orng_o(orng_o), .cc_o(cc_o), .dv_n_o(dv_n_o)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_bus(input bit second);
    if (!cfg_byte_split) return m_word;
    if (second) return {m_word[3:0], 3'b000, m_orng, 4'h0};
    return {m_word[11:4], 4'h0};
  endfunction

  // Called at a falling edge; leaves at the falling edge of the second half.
  task automatic send(input logic [1:0] ch, input logic [11:0] d, input logic fl, input logic cd);
    bit sel;
    sel = cfg_dv_from_stream ? cd : (ch != 2'b11 && cfg_dv_mask[ch]);
    in_valid = 1'b1; in_chan = ch; in_data = d; in_orng = fl; in_cdv = cd;
    check(in_ready == 1'b1, "R2 ready before accept", 16'(in_ready), 16'd1);
    @(posedge clk);
    m_code = cfg_mono ? cfg_mono_chan : ch;
    if (!cfg_hold || sel) begin
      m_word = cfg_wide ? d : {d[11:2], 2'b00};
      m_orng = fl;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 ready low first half", 16'(in_ready), 16'd0);
    check(cc_o == {m_code, 1'b0}, "R3 R4 code first half", 16'(cc_o), 16'({m_code, 1'b0}));
    check(dv_n_o == !sel, "R5 R6 R7 strobe first half", 16'(dv_n_o), 16'(!sel));
    check(op_o == exp_bus(1'b0), "R8 R9 R10 bus first half", 16'(op_o), 16'(exp_bus(1'b0)));
    check(orng_o == m_orng, "R12 flag", 16'(orng_o), 16'(m_orng));
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready second half", 16'(in_ready), 16'd1);
    check(cc_o == {m_code, 1'b1}, "R3 code second half", 16'(cc_o), 16'({m_code, 1'b1}));
    check(dv_n_o == !sel, "R5 strobe second half", 16'(dv_n_o), 16'(!sel));
    check(op_o == exp_bus(1'b1), "R10 bus second half", 16'(op_o), 16'(exp_bus(1'b1)));
  endtask

  task automatic idle_check;
    @(negedge clk);
    check(dv_n_o == 1'b1, "R5 idle strobe", 16'(dv_n_o), 16'd1);
    check(cc_o == {m_code, 1'b0}, "R3 idle code", 16'(cc_o), 16'({m_code, 1'b0}));
    check(op_o == exp_bus(1'b0), "R10 idle bus", 16'(op_o), 16'(exp_bus(1'b0)));
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act %0d exp %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(op_o == 12'h000, "R1 bus", 16'(op_o), 16'h0);
    check(orng_o == 1'b0, "R1 flag", 16'(orng_o), 16'h0);
    check(cc_o == 3'b000, "R1 code", 16'(cc_o), 16'h0);
    check(dv_n_o == 1'b1, "R1 strobe", 16'(dv_n_o), 16'h1);
    check(in_ready == 1'b1, "R1 ready", 16'(in_ready), 16'h1);

    // Sweep of strobe source, mask, hold, width, split, channel, stream bit.
    for (int src = 0; src < 2; src++)
      for (int msk = 0; msk < 8; msk++)
        for (int fm = 0; fm < 4; fm++)
          for (int hl = 0; hl < 2; hl++) begin
            cfg_dv_from_stream = src[0]; cfg_dv_mask = msk[2:0];
            cfg_wide = fm[0]; cfg_byte_split = fm[1]; cfg_hold = hl[0];
            for (int ch = 0; ch < 4; ch++)
              for (int cd = 0; cd < 2; cd++) begin
                idx++;
                send(ch[1:0], 12'((idx * 1237 + 45) % 4096), idx[0] ^ idx[2], cd[0]);
              end
            idle_check();
          end

    // R4 mono channel override
    cfg_mono = 1'b1; cfg_hold = 1'b0; cfg_dv_from_stream = 1'b0; cfg_dv_mask = 3'b111;
    for (int mc = 0; mc < 3; mc++) begin
      cfg_mono_chan = mc[1:0];
      for (int ch = 0; ch < 3; ch++) send(ch[1:0], 12'(mc * 300 + ch * 17 + 5), 1'b0, 1'b0);
    end
    cfg_mono = 1'b0;
    idle_check();

    // R11 high impedance, state still advances
    cfg_wide = 1'b1; cfg_byte_split = 1'b0;
    oe_n = 1'b1;
    in_valid = 1'b1; in_chan = 2'b01; in_data = 12'hA5C; in_orng = 1'b1;
    @(posedge clk);
    m_code = 2'b01; m_word = 12'hA5C; m_orng = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(op_o === 12'hzzz, "R11 bus float", 16'(op_o), 16'hFFFF);
    check(orng_o === 1'bz, "R11 flag float", 16'(orng_o), 16'hFFFF);
    check(cc_o === 3'bzzz, "R11 code float", 16'(cc_o), 16'hFFFF);
    check(dv_n_o === 1'bz, "R11 strobe float", 16'(dv_n_o), 16'hFFFF);
    @(negedge clk);
    oe_n = 1'b0;
    #1;
    check(op_o == 12'hA5C, "R11 state kept", 16'(op_o), 16'hA5C);
    check(cc_o == 3'b011, "R11 code kept", 16'(cc_o), 16'h3);
    idle_check();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule